// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a per-core 32-bit down-counter reached over a simple 32-bit register bus. Software writes a reload value and a control word that holds the enable, the mode, the interrupt enable and an 8-bit clock divider. While the timer runs, the counter steps down once per divided period. When it reaches zero it raises an event flag, and the interrupt line follows that flag when the interrupt enable is set.

In one-shot mode the counter stops at zero. In auto-reload mode it takes the reload value on the following divided tick and keeps going. Writes to the reload, counter and control registers follow a fixed set of stop and restart rules. These rules give zero values and a zero divider special treatment, so that a write can halt the timer without producing an event.

Top module: `cdt_timer`

## Requirements
- R1: The byte offsets in the 32-byte window are 0x00 reload, 0x04 counter, 0x08 control and 0x0C status. Offsets 0x10 to 0x1C read as zero, and writes to them change nothing. Address bits 1:0 are ignored. bus_ready_o is high in the same cycle as bus_sel_i, and a write takes effect on that clock edge.
- R2: In the control register, bit 0 is the enable, bit 1 selects auto-reload (1) or one-shot (0), bit 2 is the interrupt enable and bits 15:8 are the divider value. All other control bits read as zero.
- R3: irq_o is high exactly when the event flag (status bit 0) is set and control bit 2 is set.
- R4: Writing status with bit 0 set clears the event flag, and writing 0 leaves it alone. If a counter event lands on the same edge as the clearing write, the flag stays set.
- R5: A running counter changes once every divider+1 clock cycles. The divider phase restarts when the timer starts and when the divider field changes.
- R6: When a tick takes the counter from 1 to 0, the event flag is set. In one-shot mode the counter then holds 0 and the timer stops.
- R7: In auto-reload mode with a nonzero reload value, the tick after the counter reaches 0 loads the reload value and raises no new event.
- R8: A write can start the timer only while it is enabled and either the divider or the resulting count is nonzero. Enabling with both at zero leaves the timer idle.
- R9: In auto-reload mode with a reload value of 0, the event fires on every divided tick while the divider is nonzero. With a zero divider the timer stops after the event.
- R10: A reload write also loads the counter. Writing 0 while enabled with a zero divider stops the timer and sets no event.
- R11: A counter write of 0 while enabled with a zero divider stops the timer with no event if the mode is one-shot or the reload value is 0. In auto-reload mode with a nonzero reload value it loads the counter from the reload value and keeps running.
- R12: A control write that changes the enable or mode bit stops the timer first. A write that enables auto-reload mode with the counter at 0 and a zero divider loads the counter from the reload value and starts it.
- R13: After reset, control, status, reload and counter read 0, irq_o is low and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus transfer select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset in the timer window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the select cycle |
| bus_ready_o | output | 1 | Transfer completes this cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can collide on one clock edge: a status write that clears the event flag, and a divided tick that sets it. A tick that reloads the counter can also coincide with a status write. The bench runs auto-reload mode with a zero divider and counts edges so that a clearing write lands exactly on the tick that takes the counter from 1 to 0. It passes only if the flag is still set afterwards. A second write, timed to the reload tick, must leave the flag clear and the counter holding the reload value.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  // word indices inside the register window
  localparam int unsigned WIDX_RELOAD = 0;
  localparam int unsigned WIDX_COUNT  = 1;
  localparam int unsigned WIDX_CTRL   = 2;
  localparam int unsigned WIDX_STAT   = 3;
  localparam int unsigned NUM_REGS    = 4;
  // control word field positions
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_AR_BIT  = 1;
  localparam int unsigned CTL_IE_BIT  = 2;
  localparam int unsigned CTL_DIV_LSB = 8;
endpackage

// File: rtl/cdt_rst_sync.sv
`timescale 1ns/1ps
module cdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_busif.sv
`timescale 1ns/1ps
module cdt_busif #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              ctl_en_i,
  input  logic              ctl_ar_i,
  input  logic              ctl_ie_i,
  input  logic [DIV_W-1:0]  ctl_div_i,
  input  logic              flag_i,
  output logic              we_reload_o,
  output logic              we_count_o,
  output logic              we_ctrl_o,
  output logic              we_stat_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ready_o
);
  import cdt_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic                in_map;
  logic [NUM_REGS-1:0] reg_hit;
  logic [DATA_W-1:0]   ctl_word;
  logic                unused_lsb;

  assign word       = bus_addr_i[ADDR_W-1:2];
  assign in_map     = (word[WORD_W-1:2] == '0);
  assign unused_lsb = ^bus_addr_i[1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign reg_hit[g] = in_map && (word[1:0] == 2'(g));
  end

  assign we_reload_o = bus_sel_i && bus_wr_i && reg_hit[WIDX_RELOAD];
  assign we_count_o  = bus_sel_i && bus_wr_i && reg_hit[WIDX_COUNT];
  assign we_ctrl_o   = bus_sel_i && bus_wr_i && reg_hit[WIDX_CTRL];
  assign we_stat_o   = bus_sel_i && bus_wr_i && reg_hit[WIDX_STAT];
  assign bus_ready_o = bus_sel_i;

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_BIT] = ctl_en_i;
    ctl_word[CTL_AR_BIT] = ctl_ar_i;
    ctl_word[CTL_IE_BIT] = ctl_ie_i;
    ctl_word[CTL_DIV_LSB +: DIV_W] = ctl_div_i;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (reg_hit[WIDX_RELOAD]) bus_rdata_o = reload_i;
    if (reg_hit[WIDX_COUNT])  bus_rdata_o = count_i;
    if (reg_hit[WIDX_CTRL])   bus_rdata_o = ctl_word;
    if (reg_hit[WIDX_STAT])   bus_rdata_o = {{(DATA_W-1){1'b0}}, flag_i};
  end
endmodule

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
module cdt_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] phase_d;
  logic             phase_en;

  assign tick_o = run_i && (phase_q == div_i);

  always_comb begin
    phase_d  = phase_q;
    phase_en = 1'b0;
    if (restart_i) begin
      phase_d  = '0;
      phase_en = 1'b1;
    end else if (run_i) begin
      phase_en = 1'b1;
      phase_d  = tick_o ? '0 : phase_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  // R5
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= div_i);
endmodule

// File: rtl/cdt_engine.sv
`timescale 1ns/1ps
module cdt_engine #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_reload_i,
  input  logic             we_count_i,
  input  logic             we_ctrl_i,
  input  logic             we_stat_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ctl_en_o,
  output logic             ctl_ar_o,
  output logic             ctl_ie_o,
  output logic [DIV_W-1:0] ctl_div_o,
  output logic             flag_o,
  output logic             run_o,
  output logic             restart_o
);
  import cdt_pkg::*;

  logic [CNT_W-1:0] reload_q, count_q, count_d;
  logic             en_q, ar_q, ie_q;
  logic [DIV_W-1:0] div_q;
  logic             flag_q, flag_d, flag_set;
  logic             run_q, run_d;
  logic             count_en;
  logic             any_wr;

  logic             wd_en, wd_ar, wd_ie;
  logic [DIV_W-1:0] wd_div;
  logic             wd_zero, div_zero, reload_zero;
  logic             mode_chg, div_chg;

  assign wd_en       = wdata_i[CTL_EN_BIT];
  assign wd_ar       = wdata_i[CTL_AR_BIT];
  assign wd_ie       = wdata_i[CTL_IE_BIT];
  assign wd_div      = wdata_i[CTL_DIV_LSB +: DIV_W];
  assign wd_zero     = (wdata_i == '0);
  assign div_zero    = (div_q == '0);
  assign reload_zero = (reload_q == '0);
  assign mode_chg    = (wd_en != en_q) || (wd_ar != ar_q);
  assign div_chg     = (wd_div != div_q);
  assign any_wr      = we_reload_i || we_count_i || we_ctrl_i;
  assign count_en    = any_wr || tick_i;

  always_comb begin
    count_d   = count_q;
    run_d     = run_q;
    flag_set  = 1'b0;
    restart_o = 1'b0;
    if (we_reload_i) begin
      count_d = wdata_i;
      if (en_q && div_zero && wd_zero) run_d = 1'b0;
      else if (en_q)                   run_d = 1'b1;
      restart_o = run_d && !run_q;
    end else if (we_count_i) begin
      if (en_q && div_zero && wd_zero && (!ar_q || reload_zero)) begin
        count_d = '0;
        run_d   = 1'b0;
      end else begin
        if (en_q && ar_q && div_zero && wd_zero) count_d = reload_q;
        else                                     count_d = wdata_i;
        if (en_q && (!div_zero || count_d != '0)) run_d = 1'b1;
      end
      restart_o = run_d && !run_q;
    end else if (we_ctrl_i) begin
      if (mode_chg) run_d = 1'b0;
      if (wd_en) begin
        if (wd_ar && (count_q == '0) && (wd_div == '0)) count_d = reload_q;
        if ((wd_div != '0) || (count_d != '0)) run_d = 1'b1;
      end else begin
        run_d = 1'b0;
      end
      restart_o = mode_chg || div_chg || (run_d && !run_q);
    end else if (tick_i) begin
      if (count_q > CNT_W'(1)) begin
        count_d = count_q - CNT_W'(1);
      end else if (count_q == CNT_W'(1)) begin
        count_d  = '0;
        flag_set = 1'b1;
        if (!ar_q) run_d = 1'b0;
      end else if (ar_q && !reload_zero) begin
        count_d = reload_q;
      end else begin
        flag_set = 1'b1;
        if (!ar_q || div_zero) run_d = 1'b0;
      end
    end
  end

  assign flag_d = flag_set || (flag_q && !(we_stat_i && wdata_i[0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      count_q  <= '0;
      en_q     <= 1'b0;
      ar_q     <= 1'b0;
      ie_q     <= 1'b0;
      div_q    <= '0;
      flag_q   <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (we_reload_i) reload_q <= wdata_i;
      if (count_en)    count_q  <= count_d;
      if (we_ctrl_i) begin
        en_q  <= wd_en;
        ar_q  <= wd_ar;
        ie_q  <= wd_ie;
        div_q <= wd_div;
      end
      flag_q <= flag_d;
      run_q  <= run_d;
    end
  end

  assign reload_o  = reload_q;
  assign count_o   = count_q;
  assign ctl_en_o  = en_q;
  assign ctl_ar_o  = ar_q;
  assign ctl_ie_o  = ie_q;
  assign ctl_div_o = div_q;
  assign flag_o    = flag_q;
  assign run_o     = run_q;

  // R8
  run_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> en_q);

  // R5
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !any_wr && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R6
  oneshot_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !any_wr && !ar_q && count_q == CNT_W'(1)) |=> (!run_q && flag_q && count_q == '0));

  // R7
  reload_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !any_wr && !we_stat_i && ar_q && count_q == '0 && !reload_zero)
      |=> (count_q == $past(reload_q) && flag_q == $past(flag_q)));

  // R10
  reload_zero_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_reload_i && en_q && div_zero && wd_zero) |=> (!run_q && flag_q == $past(flag_q)));

  // R4
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_stat_i && wdata_i[0] && !tick_i) |=> !flag_q);
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              bus_ready_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic             we_reload, we_count, we_ctrl, we_stat;
  logic [CNT_W-1:0] reload, count;
  logic             ctl_en, ctl_ar, ctl_ie;
  logic [DIV_W-1:0] ctl_div;
  logic             flag, run, restart, tick;

  cdt_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cdt_busif #(.DATA_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_busif (
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .reload_i    (reload),
    .count_i     (count),
    .ctl_en_i    (ctl_en),
    .ctl_ar_i    (ctl_ar),
    .ctl_ie_i    (ctl_ie),
    .ctl_div_i   (ctl_div),
    .flag_i      (flag),
    .we_reload_o (we_reload),
    .we_count_o  (we_count),
    .we_ctrl_o   (we_ctrl),
    .we_stat_o   (we_stat),
    .bus_rdata_o (bus_rdata_o),
    .bus_ready_o (bus_ready_o)
  );

  cdt_prescale #(.DIV_W(DIV_W)) i_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .run_i     (run),
    .restart_i (restart),
    .div_i     (ctl_div),
    .tick_o    (tick)
  );

  cdt_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .we_reload_i (we_reload),
    .we_count_i  (we_count),
    .we_ctrl_i   (we_ctrl),
    .we_stat_i   (we_stat),
    .wdata_i     (bus_wdata_i),
    .tick_i      (tick),
    .reload_o    (reload),
    .count_o     (count),
    .ctl_en_o    (ctl_en),
    .ctl_ar_o    (ctl_ar),
    .ctl_ie_o    (ctl_ie),
    .ctl_div_o   (ctl_div),
    .flag_o      (flag),
    .run_o       (run),
    .restart_o   (restart)
  );

  assign irq_o = flag && ctl_ie;
endmodule

// File: tb/test_cdt_timer.sv
`timescale 1ns/1ps
module test_cdt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        ready, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [4:0] A_RLD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C;

  always #2.5 clk = ~clk;

  cdt_timer i_cdt_timer (
    .clk_i (clk), .rst_ni (rst_n),
    .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .bus_ready_o (ready), .irq_o (irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h00, 32'hDEADBEEF, 32'h0,        4'd1},  // R1 reload write
    '{1'b0, 5'h00, 32'h0,        32'hDEADBEEF, 4'd1},  // R1 reload read
    '{1'b0, 5'h04, 32'h0,        32'hDEADBEEF, 4'd10}, // R10 copied to counter
    '{1'b1, 5'h08, 32'hFFFFFFF8, 32'h0,        4'd2},  // R2 all but low bits
    '{1'b0, 5'h08, 32'h0,        32'h0000FF00, 4'd2},  // R2 only divider kept
    '{1'b1, 5'h08, 32'h00000004, 32'h0,        4'd2},  // R2 irq enable bit
    '{1'b0, 5'h08, 32'h0,        32'h00000004, 4'd2},  // R2
    '{1'b0, 5'h10, 32'h0,        32'h0,        4'd1},  // R1 unmapped
    '{1'b0, 5'h1C, 32'h0,        32'h0,        4'd1},  // R1 unmapped
    '{1'b1, 5'h14, 32'h12345678, 32'h0,        4'd1},  // R1 ignored write
    '{1'b0, 5'h00, 32'h0,        32'hDEADBEEF, 4'd1},  // R1
    '{1'b0, 5'h04, 32'h0,        32'hDEADBEEF, 4'd1},  // R1
    '{1'b1, 5'h08, 32'h00000000, 32'h0,        4'd2},  // R2
    '{1'b0, 5'h0C, 32'h0,        32'h0,        4'd3}   // R3 flag clear
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R13 reset state
    chk_reg("R13 reload", A_RLD, 32'h0);
    chk_reg("R13 counter", A_CNT, 32'h0);
    chk_reg("R13 control", A_CTL, 32'h0);
    chk_reg("R13 status", A_STS, 32'h0);
    chk("R13 irq", {31'b0, irq}, 32'h0);
    sel = 1'b1; wr = 1'b0; addr = A_STS; #1;
    chk("R1 ready", {31'b0, ready}, 32'h1);
    sel = 1'b0;
    step(1);

    // table walk, timer disabled
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) bus_write(VECS[i].a, VECS[i].d);
      else begin
        bus_read(VECS[i].a, v);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R6 one-shot, divider 0, irq enabled
    bus_write(A_RLD, 32'd3);
    bus_write(A_CTL, 32'h5);
    chk_reg("R6 start", A_CNT, 32'd3);
    step(2);
    chk_reg("R6 count", A_CNT, 32'd1);
    chk_reg("R6 no flag yet", A_STS, 32'h0);
    step(1);
    chk_reg("R6 zero", A_CNT, 32'd0);
    chk_reg("R6 flag", A_STS, 32'h1);
    chk("R3 irq on", {31'b0, irq}, 32'h1);
    step(2);
    chk_reg("R6 hold", A_CNT, 32'd0);
    bus_write(A_STS, 32'h0);
    chk_reg("R4 zero write keeps", A_STS, 32'h1);
    bus_write(A_STS, 32'h1);
    chk_reg("R4 cleared", A_STS, 32'h0);
    chk("R3 irq off", {31'b0, irq}, 32'h0);

    // R5 divider 2
    bus_write(A_CTL, 32'h0);
    bus_write(A_RLD, 32'd2);
    bus_write(A_CTL, 32'h0201);
    chk_reg("R5 start", A_CNT, 32'd2);
    step(2);
    chk_reg("R5 hold 2", A_CNT, 32'd2);
    step(1);
    chk_reg("R5 first tick", A_CNT, 32'd1);
    step(2);
    chk_reg("R5 hold 1", A_CNT, 32'd1);
    step(1);
    chk_reg("R5 second tick", A_CNT, 32'd0);
    chk_reg("R6 flag div", A_STS, 32'h1);
    chk("R3 masked", {31'b0, irq}, 32'h0);

    // R7 auto-reload, divider 0
    bus_write(A_CTL, 32'h0);
    bus_write(A_STS, 32'h1);
    bus_write(A_RLD, 32'd2);
    bus_write(A_CTL, 32'h3);
    step(2);
    chk_reg("R7 zero", A_CNT, 32'd0);
    chk_reg("R7 event", A_STS, 32'h1);
    bus_write(A_STS, 32'h1);          // lands on reload tick
    chk_reg("R7 reloaded", A_CNT, 32'd2);
    chk_reg("R7 no new event", A_STS, 32'h0);
    step(1);
    chk_reg("R7 count", A_CNT, 32'd1);
    bus_write(A_STS, 32'h1);          // lands on 1->0 tick
    chk_reg("R4 event wins", A_STS, 32'h1);
    chk_reg("R4 counter", A_CNT, 32'd0);

    // R9 zero reload, divider 1
    bus_write(A_CTL, 32'h0);
    bus_write(A_STS, 32'h1);
    bus_write(A_RLD, 32'd0);
    bus_write(A_CTL, 32'h0107);
    chk_reg("R9 start", A_STS, 32'h0);
    step(1);
    chk_reg("R9 before tick", A_STS, 32'h0);
    step(1);
    chk_reg("R9 event", A_STS, 32'h1);
    chk("R9 irq", {31'b0, irq}, 32'h1);
    bus_write(A_STS, 32'h1);
    chk_reg("R9 cleared", A_STS, 32'h0);
    step(1);
    chk_reg("R9 again", A_STS, 32'h1);
    bus_write(A_CTL, 32'h0007);
    step(1);
    bus_write(A_STS, 32'h1);
    step(3);
    chk_reg("R9 stopped", A_STS, 32'h0);
    chk("R9 irq quiet", {31'b0, irq}, 32'h0);

    // R8 enable with zero divider and zero count
    bus_write(A_CTL, 32'h0);
    bus_write(A_STS, 32'h1);
    bus_write(A_CTL, 32'h1);
    step(3);
    chk_reg("R8 idle flag", A_STS, 32'h0);
    chk_reg("R8 idle count", A_CNT, 32'h0);

    // R10 reload writes
    bus_write(A_RLD, 32'd5);
    chk_reg("R10 copy", A_CNT, 32'd5);
    step(1);
    chk_reg("R10 running", A_CNT, 32'd4);
    bus_write(A_RLD, 32'd0);
    chk_reg("R10 zero count", A_CNT, 32'd0);
    step(3);
    chk_reg("R10 no event", A_STS, 32'h0);
    bus_write(A_RLD, 32'd7);
    step(1);
    chk_reg("R10 restart", A_CNT, 32'd6);

    // R11 counter writes
    bus_write(A_CNT, 32'd0);
    chk_reg("R11 oneshot zero", A_CNT, 32'd0);
    step(2);
    chk_reg("R11 stays", A_CNT, 32'd0);
    chk_reg("R11 no event", A_STS, 32'h0);
    bus_write(A_CTL, 32'h3);
    chk_reg("R12 reload on enable", A_CNT, 32'd7);
    step(1);
    chk_reg("R12 running", A_CNT, 32'd6);
    bus_write(A_CNT, 32'd0);
    chk_reg("R11 periodic zero", A_CNT, 32'd7);
    step(1);
    chk_reg("R11 still running", A_CNT, 32'd6);
    bus_write(A_CNT, 32'd4);
    step(1);
    chk_reg("R11 value", A_CNT, 32'd3);
    bus_write(A_CTL, 32'h2);
    chk_reg("R12 halt", A_CNT, 32'd3);
    step(3);
    chk_reg("R12 held", A_CNT, 32'd3);
    chk_reg("R12 no event", A_STS, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule